// File: doc/BRIEF.md
# Four-Channel Two-Dimensional Receive DMA Engine

This block moves 128-bit quad words from four independent receive streams into the write port of a word-addressed internal memory. Each channel walks a two-dimensional region. An inner (X) loop steps the address by a programmable stride for a programmable number of words. At the end of each row, an outer (Y) step applies a second stride and starts the next row, until the row count is used up. A source offers a word by holding its valid line high. The engine takes at most one word per cycle, chosen among the ready channels by a rotating-priority arbiter.

When a channel writes the last word of its region, it raises a one-cycle interrupt pulse on its own line and goes idle. Coming out of reset, every channel is already armed with a boot descriptor: a 256-word block to addresses 0 to 255. Boot data can therefore land in memory without any prior programming. After that, software reprograms idle channels through a small register write port. A channel is armed by writing its row count.

Top module: `dma2d_rx`

## Requirements
- R1: Each channel holds six registers, selected by `cfg_sel`: 0 = address index, 1 = X count (written to both the reload value and the live count), 2 = X modify, 3 = Y count, 4 = Y modify. Address arithmetic is modulo 2^AW, so a large modify value acts as a negative stride.
- R2: The winner is the first requesting channel found when scanning upward from the rotating pointer, wrapping from channel NCH-1 to channel 0. After each grant, the pointer moves to the winner plus one. At most one `rx_ready` bit is high in any cycle.
- R3: For each granted word, `mem_wdata` carries the winner's 128-bit `rx_data` slice unchanged, and `mem_addr` carries that channel's current address.
- R4: After reset, all four channels are active with index 0, X count 256, X modify 1, Y count 1 and Y modify 0. A source presenting 256 words therefore writes addresses 0 to 255 in order.
- R5: On the cycle after a channel's final word is written, `irq` bit c is high for exactly one cycle. The channel then makes no further writes, even while its valid stays high.
- R6: A word moves only in a cycle where the channel is active and its `rx_valid` is high. `rx_ready` marks the word taken in that cycle, and `mem_we` is high exactly when some `rx_ready` bit is. A lone request is granted combinationally in the same cycle.
- R7: After each word the address advances by X modify and the X count decrements. When the X count reaches its last word, the address advances by Y modify instead, the X count reloads, and the Y count decrements. For example, index 10, X count 3, X modify 2, Y count 2 and Y modify 5 give addresses 10, 12, 14, 19, 21, 23.
- R8: Writing a nonzero Y count to an idle channel arms it. Writing zero leaves it idle.
- R9: Writes to any register of an active channel are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_valid | input | NCH | Per-channel word-available flag |
| rx_data | input | NCH*DW | Per-channel quad word, channel c in bits [c*DW +: DW] |
| rx_ready | output | NCH | One-hot: the word of this channel is taken this cycle |
| cfg_we | input | 1 | Register write strobe |
| cfg_ch | input | $clog2(NCH) | Channel addressed by the write |
| cfg_sel | input | 3 | Register selector (see R1) |
| cfg_wdata | input | AW | Write data |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | DW | Memory write data |
| irq | output | NCH | Per-channel end-of-block pulse |

## Verification
The hardest situation to reach from the ports is the rotation pointer sitting at a chosen value while only some channels request. The pointer is not visible, and reset leaves every channel busy with a long boot block. The stimulus first drains all four boot blocks with every source valid, which also fixes the grant order and the staggered interrupt pulses. It then runs a single-channel two-dimensional transfer, which leaves the pointer just past that channel. Finally, two channels are armed so that the expected alternation is known to start from the higher-numbered one.

// File: rtl/dma2d_rx.sv
module dma2d_rx #(
  parameter int NCH      = 4,
  parameter int DW       = 128,
  parameter int AW       = 16,
  parameter int BOOT_LEN = 256
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NCH-1:0]         rx_valid,
  input  logic [NCH*DW-1:0]      rx_data,
  output logic [NCH-1:0]         rx_ready,
  input  logic                   cfg_we,
  input  logic [$clog2(NCH)-1:0] cfg_ch,
  input  logic [2:0]             cfg_sel,
  input  logic [AW-1:0]          cfg_wdata,
  output logic                   mem_we,
  output logic [AW-1:0]          mem_addr,
  output logic [DW-1:0]          mem_wdata,
  output logic [NCH-1:0]         irq
);
  localparam int CHW = $clog2(NCH);
  localparam logic [AW-1:0] ONE = AW'(1);

  logic [NCH-1:0] active;
  logic [AW-1:0]  idx [NCH];
  logic [AW-1:0]  xcnt[NCH];
  logic [AW-1:0]  xld [NCH];
  logic [AW-1:0]  xmod[NCH];
  logic [AW-1:0]  ycnt[NCH];
  logic [AW-1:0]  ymod[NCH];
  logic [CHW-1:0] ptr, win;
  logic           any;
  logic [NCH-1:0] req;

  assign req = active & rx_valid;

  always_comb begin
    any = 1'b0;
    win = ptr;
    for (int k = 0; k < NCH; k++) begin
      if (!any && req[(int'(ptr) + k) % NCH]) begin
        any = 1'b1;
        win = CHW'((int'(ptr) + k) % NCH);
      end
    end
  end

  assign rx_ready  = any ? (NCH'(1) << win) : '0;
  assign mem_we    = any;
  assign mem_addr  = idx[win];
  assign mem_wdata = rx_data[int'(win)*DW +: DW];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr <= '0;
    else if (any) ptr <= win + CHW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= '1;
      irq    <= '0;
      for (int c = 0; c < NCH; c++) begin
        idx[c]  <= '0;
        xcnt[c] <= AW'(BOOT_LEN);
        xld[c]  <= AW'(BOOT_LEN);
        xmod[c] <= ONE;
        ycnt[c] <= ONE;
        ymod[c] <= '0;
      end
    end else begin
      for (int c = 0; c < NCH; c++) begin
        irq[c] <= rx_ready[c] && xcnt[c] == ONE && ycnt[c] == ONE;
        if (rx_ready[c]) begin
          if (xcnt[c] == ONE) begin
            idx[c]  <= idx[c] + ymod[c];
            xcnt[c] <= xld[c];
            ycnt[c] <= ycnt[c] - ONE;
            if (ycnt[c] == ONE) active[c] <= 1'b0;
          end else begin
            idx[c]  <= idx[c] + xmod[c];
            xcnt[c] <= xcnt[c] - ONE;
          end
        end else if (cfg_we && int'(cfg_ch) == c && !active[c]) begin
          case (cfg_sel)
            3'd0: idx[c] <= cfg_wdata;
            3'd1: begin xld[c] <= cfg_wdata; xcnt[c] <= cfg_wdata; end
            3'd2: xmod[c] <= cfg_wdata;
            3'd3: begin ycnt[c] <= cfg_wdata; active[c] <= cfg_wdata != '0; end
            3'd4: ymod[c] <= cfg_wdata;
            default: ;
          endcase
        end
      end
    end
  end
endmodule

module dma2d_rx_chk #(
  parameter int NCH = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NCH-1:0] rx_valid,
  input logic [NCH-1:0] rx_ready,
  input logic           mem_we,
  input logic [NCH-1:0] irq,
  input logic [NCH-1:0] active
);
  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rx_ready)); // R2
  AST_READY_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_ready & ~rx_valid) == '0); // R6
  AST_WE_TRACKS_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we == (rx_ready != '0)); // R6
  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (irq != '0) |=> ((irq & $past(irq)) == '0)); // R5
  AST_IRQ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (irq & active) == '0); // R5
endmodule

bind dma2d_rx dma2d_rx_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_ready(rx_ready),
  .mem_we(mem_we), .irq(irq), .active(active)
);

// File: tb/tb_dma2d_rx.sv
module tb_dma2d_rx;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 4;
  localparam int DW  = 128;
  localparam int AW  = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NCH-1:0] rx_valid = '0;
  logic [NCH*DW-1:0] rx_data;
  logic [NCH-1:0] rx_ready;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_ch = '0;
  logic [2:0] cfg_sel = '0;
  logic [AW-1:0] cfg_wdata = '0;
  logic mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic [NCH-1:0] irq;
  int tests = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma2d_rx dut (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_ready(rx_ready), .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .irq(irq)
  );

  function automatic logic [DW-1:0] word_of(int c);
    return {64'hA5A5_0000_0000_0000 | 64'(c), 64'(c)};
  endfunction

  initial for (int c = 0; c < NCH; c++) rx_data[c*DW +: DW] = word_of(c);

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cfg(input int ch, input int sel, input int val);
    @(negedge clk);
    cfg_ch = 2'(ch); cfg_sel = 3'(sel); cfg_wdata = AW'(val); cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic t_reset;
    #1;
    chk(irq == '0, "R4 reset irq", irq, 0);
    chk(mem_we == 1'b0, "R6 reset no write", mem_we, 0);
  endtask

  task automatic t_ignore_active;
    cfg(0, 0, 500);
    cfg(0, 2, 7);
    cfg(1, 3, 0);
  endtask

  task automatic t_boot;
    @(negedge clk);
    rx_valid = 4'hF;
    for (int k = 0; k < 1024; k++) begin
      logic [3:0] ei;
      #1;
      ei = (k >= 1021) ? 4'(1 << (k - 1021)) : 4'b0;
      chk(mem_we == 1'b1, "R6 boot write", mem_we, 1);
      chk(int'(mem_wdata[1:0]) == k % 4, "R2 rotation order", mem_wdata[1:0], k % 4);
      chk(int'(mem_addr) == k / 4, (k < 8) ? "R9 boot addr untouched" : "R4 boot addr",
          mem_addr, k / 4);
      chk(mem_wdata == word_of(k % 4), "R3 data passthrough", mem_wdata[7:0], k % 4);
      chk(irq == ei, "R5 boot irq", irq, ei);
      @(negedge clk);
    end
    #1;
    chk(irq == 4'b1000, "R5 last irq", irq, 8);
    chk(mem_we == 1'b0, "R5 idle after block", mem_we, 0);
    @(negedge clk);
    #1;
    chk(irq == '0, "R5 irq one cycle", irq, 0);
    rx_valid = '0;
  endtask

  task automatic t_noarm;
    cfg(3, 3, 0);
    @(negedge clk);
    rx_valid = 4'b1000;
    #1;
    chk(mem_we == 1'b0, "R8 zero count not armed", mem_we, 0);
    @(negedge clk);
    #1;
    chk(mem_we == 1'b0, "R8 still idle", mem_we, 0);
    rx_valid = '0;
  endtask

  task automatic t_2d;
    int exp_a[6] = '{10, 12, 14, 19, 21, 23};
    cfg(2, 0, 10);
    cfg(2, 1, 3);
    cfg(2, 2, 2);
    cfg(2, 4, 5);
    cfg(2, 3, 2);
    @(negedge clk);
    #1;
    chk(mem_we == 1'b0, "R6 no write without valid", mem_we, 0);
    rx_valid = 4'b0100;
    for (int k = 0; k < 6; k++) begin
      #1;
      chk(rx_ready == 4'b0100, "R6 lone request same cycle", rx_ready, 4);
      chk(int'(mem_addr) == exp_a[k], "R7 2D address", mem_addr, exp_a[k]);
      chk(irq == '0, "R5 no early irq", irq, 0);
      @(negedge clk);
    end
    #1;
    chk(irq == 4'b0100, "R5 2D irq", irq, 4);
    chk(mem_we == 1'b0, "R5 2D idle", mem_we, 0);
    @(negedge clk);
    #1;
    chk(irq == '0, "R5 2D irq pulse", irq, 0);
    rx_valid = '0;
  endtask

  task automatic t_rotate;
    int exp_c[4] = '{3, 1, 3, 1};
    int exp_a[4] = '{80, 40, 81, 41};
    cfg(1, 0, 40); cfg(1, 1, 2); cfg(1, 2, 1); cfg(1, 4, 0); cfg(1, 3, 1);
    cfg(3, 0, 80); cfg(3, 1, 2); cfg(3, 2, 1); cfg(3, 4, 0); cfg(3, 3, 1);
    @(negedge clk);
    rx_valid = 4'b1010;
    for (int k = 0; k < 4; k++) begin
      #1;
      chk(int'(mem_wdata[1:0]) == exp_c[k], "R2 pointer past winner", mem_wdata[1:0], exp_c[k]);
      chk(int'(mem_addr) == exp_a[k], "R1 programmed addr", mem_addr, exp_a[k]);
      @(negedge clk);
    end
    #1;
    chk(irq == 4'b0010, "R5 both done", irq, 2);
    rx_valid = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_ignore_active();
    t_boot();
    t_2d();
    t_noarm();
    t_rotate();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule